// File: doc/BRIEF.md
# Inverted Page Table Lookup

This block is a translation table with one slot for each physical frame. Each slot records which virtual page currently lives in that frame. A lookup compares the virtual page number of the incoming address against every slot in parallel. A match can occur in only one slot, and the position of that slot is the physical frame number. The frame number is joined with the untouched page offset to form the physical address. When no slot matches, the response flags a miss, and the ordinary page-table walk elsewhere has to resolve the address.

Software keeps the table up to date through a single write port. A write either loads a frame's slot with a virtual page number or invalidates it. Loading a page number that another valid slot already holds retires that older slot in the same write, so a lookup never finds two matching frames. Lookup responses are registered and arrive one cycle after the request. A lookup issued in the same cycle as a write sees the table as it was before that write.

Top module: `ipt_lookup`

## Requirements
- R1: After reset every slot is invalid, so any lookup misses, including one for virtual page number 0; the response outputs are all zero while no response is pending.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high, and low otherwise.
- R3: A lookup whose virtual page number (address bits above the offset) equals the page held by a valid slot returns `rsp_hit`=1 and `rsp_frame` equal to that slot's index.
- R4: On a hit, `rsp_paddr` equals the frame number in its upper bits and the request's low OFF_W offset bits in its lower bits.
- R5: A lookup that matches no valid slot returns `rsp_miss`=1, `rsp_hit`=0, and zero on `rsp_paddr` and `rsp_frame`.
- R6: A write with `wr_load`=1 stores `wr_vpn` into slot `wr_frame` and marks it valid; lookups issued from the following cycle on can hit it.
- R7: A write with `wr_load`=0 invalidates slot `wr_frame`, after which its old page misses.
- R8: Loading a page number already held by a different valid slot invalidates that other slot in the same write.
- R9: A lookup issued in the same cycle as a write is answered from the table contents before that write.
- R10: While `rsp_valid` is high, exactly one of `rsp_hit` and `rsp_miss` is high; while it is low, both are low.
- R11: Reloading a valid slot with a new page number replaces the old one, which then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vaddr | input | VPN_W+OFF_W | Virtual address to translate |
| wr_en | input | 1 | Table write strobe |
| wr_load | input | 1 | 1 loads the slot, 0 invalidates it |
| wr_frame | input | PFN_W | Slot (physical frame) being written |
| wr_vpn | input | VPN_W | Virtual page number to store |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No slot matched; fall back to the page-table walk |
| rsp_frame | output | PFN_W | Matching physical frame number |
| rsp_paddr | output | PFN_W+OFF_W | Translated physical address |

## Verification
Directed lookups run against an empty table, then against slots at the lowest, a middle and the highest frame, with differing offsets. These separate a correct frame encoding and offset pass-through from ones that are off by one or truncated. Sequences that clear a slot, reload a slot with a new page, and move a page between frames show whether stale slots really leave the match set. A lookup issued alongside a write of the same page shows which table contents answer it. A long random run over a small pool of page numbers then drives many duplicate loads and collisions through the reference model.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    typedef enum logic {
        OP_CLEAR = 1'b0,
        OP_LOAD  = 1'b1
    } wr_op_e;
endpackage

// File: rtl/ipt_table.sv
module ipt_table #(
    parameter int FRAMES = 32,
    parameter int VPN_W  = 20,
    localparam int PFN_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  ipt_pkg::wr_op_e                wr_op,
    input  logic [PFN_W-1:0]               wr_frame,
    input  logic [VPN_W-1:0]               wr_vpn,
    output logic [FRAMES-1:0]              ent_vld,
    output logic [FRAMES-1:0][VPN_W-1:0]   ent_vpn
);
    typedef struct packed {
        logic [FRAMES-1:0]            vld;
        logic [FRAMES-1:0][VPN_W-1:0] vpn;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            for (int i = 0; i < FRAMES; i++) begin
                if (PFN_W'(i) == wr_frame) begin
                    if (wr_op == ipt_pkg::OP_LOAD) begin
                        tbl_d.vld[i] = 1'b1;
                        tbl_d.vpn[i] = wr_vpn;
                    end else begin
                        tbl_d.vld[i] = 1'b0;
                    end
                end else if (wr_op == ipt_pkg::OP_LOAD &&
                             tbl_q.vld[i] && tbl_q.vpn[i] == wr_vpn) begin
                    // retire an older holder of the same page
                    tbl_d.vld[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign ent_vld = tbl_q.vld;
    assign ent_vpn = tbl_q.vpn;
endmodule

// File: rtl/ipt_match.sv
module ipt_match #(
    parameter int FRAMES = 32,
    parameter int VPN_W  = 20
) (
    input  logic [FRAMES-1:0]            ent_vld,
    input  logic [FRAMES-1:0][VPN_W-1:0] ent_vpn,
    input  logic [VPN_W-1:0]             key,
    output logic [FRAMES-1:0]            hit_vec
);
    for (genvar g = 0; g < FRAMES; g++) begin : g_cmp
        assign hit_vec[g] = ent_vld[g] && (ent_vpn[g] == key);
    end
endmodule

// File: rtl/ipt_encode.sv
module ipt_encode #(
    parameter int FRAMES = 32,
    localparam int PFN_W = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic [FRAMES-1:0] hit_vec,
    output logic              any,
    output logic [PFN_W-1:0]  index
);
    always_comb begin
        index = '0;
        for (int i = 0; i < FRAMES; i++) begin
            if (hit_vec[i]) begin
                index = index | PFN_W'(i);
            end
        end
    end

    assign any = |hit_vec;
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
    parameter int FRAMES     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int VPN_W      = 20,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int PFN_W = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int VA_W  = VPN_W + OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             wr_en,
    input  logic             wr_load,
    input  logic [PFN_W-1:0] wr_frame,
    input  logic [VPN_W-1:0] wr_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic [PFN_W-1:0] rsp_frame,
    output logic [PA_W-1:0]  rsp_paddr
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             miss;
        logic [PFN_W-1:0] frame;
        logic [PA_W-1:0]  paddr;
    } rsp_t;

    logic [FRAMES-1:0]            ent_vld;
    logic [FRAMES-1:0][VPN_W-1:0] ent_vpn;
    logic [FRAMES-1:0]            hit_vec;
    logic                         any_hit;
    logic [PFN_W-1:0]             hit_idx;
    ipt_pkg::wr_op_e              wr_op;

    assign wr_op = wr_load ? ipt_pkg::OP_LOAD : ipt_pkg::OP_CLEAR;

    ipt_table #(.FRAMES(FRAMES), .VPN_W(VPN_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_op    (wr_op),
        .wr_frame (wr_frame),
        .wr_vpn   (wr_vpn),
        .ent_vld  (ent_vld),
        .ent_vpn  (ent_vpn)
    );

    ipt_match #(.FRAMES(FRAMES), .VPN_W(VPN_W)) u_match (
        .ent_vld (ent_vld),
        .ent_vpn (ent_vpn),
        .key     (lk_vaddr[VA_W-1:OFF_W]),
        .hit_vec (hit_vec)
    );

    ipt_encode #(.FRAMES(FRAMES)) u_encode (
        .hit_vec (hit_vec),
        .any     (any_hit),
        .index   (hit_idx)
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lk_valid;
        if (lk_valid) begin
            if (any_hit) begin
                rsp_d.hit   = 1'b1;
                rsp_d.frame = hit_idx;
                rsp_d.paddr = {hit_idx, lk_vaddr[OFF_W-1:0]};
            end else begin
                rsp_d.miss  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_miss  = rsp_q.miss;
    assign rsp_frame = rsp_q.frame;
    assign rsp_paddr = rsp_q.paddr;
endmodule

// File: rtl/ipt_lookup_chk.sv
module ipt_lookup_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 17,
    parameter int PFN_W = 5,
    parameter int OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic [PFN_W-1:0] rsp_frame,
    input logic [PA_W-1:0]  rsp_paddr
);
    // R2
    req_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R2
    idle_gives_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1);

    // R10
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && rsp_paddr == '0));

    // R4
    offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));

    // R4
    frame_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_paddr[PA_W-1:OFF_W] == rsp_frame);

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_paddr == '0 && rsp_frame == '0));
endmodule

bind ipt_lookup ipt_lookup_chk #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .PFN_W(PFN_W),
    .OFF_W(OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_frame (rsp_frame),
    .rsp_paddr (rsp_paddr)
);

// File: tb/ipt_lookup_test.sv
`timescale 1ns/1ps
module ipt_lookup_test;
    localparam int FRAMES = 32;
    localparam int VPN_W  = 20;
    localparam int OFF_W  = 12;
    localparam int PFN_W  = 5;
    localparam int VA_W   = VPN_W + OFF_W;
    localparam int PA_W   = PFN_W + OFF_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [VA_W-1:0]  lk_vaddr = '0;
    logic             wr_en = 1'b0;
    logic             wr_load = 1'b0;
    logic [PFN_W-1:0] wr_frame = '0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic             rsp_valid, rsp_hit, rsp_miss;
    logic [PFN_W-1:0] rsp_frame;
    logic [PA_W-1:0]  rsp_paddr;

    always #2.5 clk = ~clk;

    ipt_lookup uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .wr_en(wr_en), .wr_load(wr_load), .wr_frame(wr_frame), .wr_vpn(wr_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_frame(rsp_frame), .rsp_paddr(rsp_paddr)
    );

    int checks = 0;
    int errors = 0;

    // behavioural model of the table
    bit               m_vld [FRAMES];
    logic [VPN_W-1:0] m_vpn [FRAMES];

    task automatic compare(input string req, input logic ev, eh, em,
                           input logic [PFN_W-1:0] ef, input logic [PA_W-1:0] ep);
        checks++;
        if (rsp_valid !== ev || rsp_hit !== eh || rsp_miss !== em ||
            rsp_frame !== ef || rsp_paddr !== ep) begin
            errors++;
            $display("FAIL %s: got v=%0b h=%0b m=%0b f=%0d pa=%h, expected v=%0b h=%0b m=%0b f=%0d pa=%h",
                     req, rsp_valid, rsp_hit, rsp_miss, rsp_frame, rsp_paddr,
                     ev, eh, em, ef, ep);
        end
    endtask

    // one clock: drive a lookup and/or a write, then check the response
    task automatic step(input string req, input logic lv, input logic [VA_W-1:0] va,
                        input logic we, input logic ld, input logic [PFN_W-1:0] wf,
                        input logic [VPN_W-1:0] wv);
        logic             eh, em;
        logic [PFN_W-1:0] ef;
        logic [PA_W-1:0]  ep;
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va;
        wr_en = we; wr_load = ld; wr_frame = wf; wr_vpn = wv;
        eh = 1'b0; em = 1'b0; ef = '0; ep = '0;
        if (lv) begin
            em = 1'b1;
            for (int i = 0; i < FRAMES; i++) begin
                if (m_vld[i] && m_vpn[i] == va[VA_W-1:OFF_W]) begin
                    eh = 1'b1; em = 1'b0; ef = PFN_W'(i);
                    ep = {PFN_W'(i), va[OFF_W-1:0]};
                end
            end
        end
        if (we) begin
            if (ld) begin
                for (int i = 0; i < FRAMES; i++)
                    if (m_vld[i] && m_vpn[i] == wv) m_vld[i] = 0;
                m_vld[wf] = 1; m_vpn[wf] = wv;
            end else begin
                m_vld[wf] = 0;
            end
        end
        @(posedge clk);
        #1;
        compare(req, lv, eh, em, ef, ep);
    endtask

    function automatic logic [VA_W-1:0] va_of(input logic [VPN_W-1:0] p,
                                              input logic [OFF_W-1:0] o);
        return {p, o};
    endfunction

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < FRAMES; i++) begin m_vld[i] = 0; m_vpn[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1", 0, 0, 0, '0, '0);
        // R1: empty table, page 0 must still miss
        step("R1", 1, va_of(20'h00000, 12'h000), 0, 0, 0, 0);
        step("R1", 1, va_of(20'h00000, 12'hFFF), 0, 0, 0, 0);
        step("R2", 0, va_of(20'h00000, 12'h000), 0, 0, 0, 0);
        // R6 load, then R3/R4 hits
        step("R6", 0, '0, 1, 1, 5'd5, 20'h12345);
        step("R3", 1, va_of(20'h12345, 12'hABC), 0, 0, 0, 0);
        step("R4", 1, va_of(20'h12345, 12'h001), 0, 0, 0, 0);
        step("R6", 0, '0, 1, 1, 5'd0, 20'hFFFFF);
        step("R6", 0, '0, 1, 1, 5'd31, 20'h00001);
        step("R3", 1, va_of(20'hFFFFF, 12'h7F0), 0, 0, 0, 0);
        step("R3", 1, va_of(20'h00001, 12'hFFF), 0, 0, 0, 0);
        step("R5", 1, va_of(20'h00002, 12'h123), 0, 0, 0, 0);
        // R7 clear
        step("R7", 0, '0, 1, 0, 5'd5, 20'h0);
        step("R7", 1, va_of(20'h12345, 12'hABC), 0, 0, 0, 0);
        // R8 move a page between frames
        step("R8", 0, '0, 1, 1, 5'd3, 20'hABCDE);
        step("R8", 0, '0, 1, 1, 5'd9, 20'hABCDE);
        step("R8", 1, va_of(20'hABCDE, 12'h010), 0, 0, 0, 0);
        step("R8", 0, '0, 1, 0, 5'd9, 20'h0);
        step("R8", 1, va_of(20'hABCDE, 12'h010), 0, 0, 0, 0);
        // R9 same-cycle write and lookup
        step("R9", 1, va_of(20'h77777, 12'h444), 1, 1, 5'd7, 20'h77777);
        step("R9", 1, va_of(20'h77777, 12'h444), 0, 0, 0, 0);
        step("R9", 1, va_of(20'h77777, 12'h555), 1, 0, 5'd7, 20'h0);
        step("R9", 1, va_of(20'h77777, 12'h555), 0, 0, 0, 0);
        // R11 reload a frame with a new page
        step("R11", 0, '0, 1, 1, 5'd0, 20'h0BEEF);
        step("R11", 1, va_of(20'hFFFFF, 12'h7F0), 0, 0, 0, 0);
        step("R11", 1, va_of(20'h0BEEF, 12'h7F0), 0, 0, 0, 0);
        // random traffic over a small page pool
        for (int n = 0; n < 600; n++) begin
            logic lv, we, ld;
            logic [PFN_W-1:0] wf;
            logic [VPN_W-1:0] pv, wv;
            logic [OFF_W-1:0] off;
            lv  = 1'($urandom_range(0, 3) != 0);
            we  = 1'($urandom_range(0, 2) == 0);
            ld  = 1'($urandom_range(0, 3) != 0);
            wf  = PFN_W'($urandom_range(0, FRAMES - 1));
            pv  = VPN_W'($urandom_range(0, 7));
            wv  = VPN_W'($urandom_range(0, 7));
            off = OFF_W'($urandom);
            step("R3/R5 random", lv, va_of(pv, off), we, ld, wf, wv);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule